// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block keeps one request flag for each of eight external interrupt lines and presents them as a 16-bit status word on a synchronous register port. Every line has its own 2-bit sense code. The code chooses low-level detection or detection of falling, rising or both edges. Each pin first crosses into the clock domain through a flop chain. An edge is then found by comparing the synchronized value with a copy one cycle older.

In low-level mode a flag simply mirrors the inverted pin, with a fixed delay. In the three edge modes a flag is sticky. Software may drop it only by a two-step handshake: a register read must return that bit as 1, and a later write must carry 0 in that bit. The flag also drops when the interrupt controller acknowledges that line. A new edge arriving in the same cycle as a clear keeps the flag set, so no request is lost.

The flags drive a per-line request vector and a single OR of all lines. Arbitration and vectoring belong to the consumer of these outputs.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset every flag is 0, `rd_data` reads 0x0000, `req` is 0 and `any_req` is 0, provided the pins are held high.
- R2: Register bits 15 to 8 always read 0, and data written to them has no effect on any flag.
- R3: Register bit i (i = 0 to 7) is the flag of line i, and `req[i]` equals that bit. `any_req` is 1 exactly when at least one flag is 1.
- R4: With sense code 00 (low level) on a line, its flag equals the inverse of its pin as sampled three clock edges earlier. That delay is two synchronizer stages plus the flag register.
- R5: With sense code 01 (falling), 10 (rising) or 11 (both), the line's sense code is taken from `sense_sel[2i+1:2i]`. A matching pin edge sets the flag on the third clock edge after the pin changes.
- R6: In an edge mode a set flag stays 1 while no clear occurs, whatever the pin does. An edge of the unselected direction never sets the flag.
- R7: In an edge mode, writing 0 to a flag that has not been read as 1 since the last write leaves it unchanged. Writing 1 never sets a flag.
- R8: A read (`rd_en`) that returns a bit as 1 arms that bit's marker. The next write with 0 in that bit clears the flag on that clock edge. Any write disarms all markers, so a write with 1 in the bit keeps the flag and spends the marker.
- R9: In an edge mode, `ack[i]` high at a clock edge clears flag i. In low-level mode, `ack` and writes have no effect on the flag.
- R10: If a matching edge and a clear (write or acknowledge) fall on the same clock edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Register read strobe; arms markers for bits read as 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; bit i is the clear request for line i (0 clears if armed) |
| rd_data | output | 16 | Register contents: flags in bits 7..0, zeros above |
| pin_in | input | 8 | External interrupt pins, asynchronous |
| sense_sel | input | 16 | Two bits per line: 00 low level, 01 falling, 10 rising, 11 both |
| ack | input | 8 | Per-line interrupt acknowledge |
| req | output | 8 | Per-line request, equal to the flags |
| any_req | output | 1 | OR of all flags |

## Verification
The bench builds the block with its default parameters: eight lines, a 16-bit register and two synchronizer stages. Eight lines are few enough that all 256 pin patterns can be swept in low-level mode. Every sense code is also driven on every line with both edge directions, so the full bit mapping and every mode/edge pairing are checked against arithmetic expectations. The fixed three-cycle pin-to-flag delay lets the bench put a write clear or an acknowledge on exactly the clock edge where a new edge lands, which exercises the set-over-clear rule.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    // True when the observed transition matches the selected sense code.
    function automatic logic edge_match(input sense_e s, input logic rose, input logic fell);
        logic m;
        case (s)
            SENSE_FALL: m = fell;
            SENSE_RISE: m = rose;
            SENSE_BOTH: m = rose | fell;
            default:    m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rose,
    output logic fell
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= {STAGES{IDLE}};
            s_q.prev  <= IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.chain[STAGES-1];
    assign rose  = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fell  = ~s_q.chain[STAGES-1] & s_q.prev;

endmodule

// File: rtl/irqf_flag.sv
module irqf_flag
    import irqf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e sense,
    input  logic   level,
    input  logic   rose,
    input  logic   fell,
    input  logic   rd_en,
    input  logic   wr_en,
    input  logic   wr_bit,
    input  logic   ack,
    output logic   flag
);
    typedef struct packed {
        logic flag;
        logic marked;
    } flag_t;

    flag_t f_d, f_q;
    logic  hit;
    logic  sw_clear;
    logic  edge_mode;

    assign hit       = edge_match(sense, rose, fell);
    assign edge_mode = (sense != SENSE_LOW);
    assign sw_clear  = wr_en & f_q.marked & ~wr_bit;

    always_comb begin
        f_d = f_q;
        if (!edge_mode) begin
            f_d.flag = ~level;
        end else if (hit) begin
            f_d.flag = 1'b1;
        end else if (ack || sw_clear) begin
            f_d.flag = 1'b0;
        end
        if (wr_en) begin
            f_d.marked = 1'b0;
        end else if (rd_en && f_q.flag) begin
            f_d.marked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flag = f_q.flag;

    assert_level_tracks_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_LOW) |=> (flag == !$past(level)));

    assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && hit) |=> flag);

    assert_hold_without_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && flag && !ack && !(wr_en && f_q.marked && !wr_bit)) |=> flag);

    assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && !hit && !flag) |=> !flag);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !hit) |=> !flag);

endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
    import irqf_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int REG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    output logic [REG_W-1:0]       rd_data,
    input  logic [NUM_LINES-1:0]   pin_in,
    input  logic [2*NUM_LINES-1:0] sense_sel,
    input  logic [NUM_LINES-1:0]   ack,
    output logic [NUM_LINES-1:0]   req,
    output logic                   any_req
);
    localparam int PAD_W = REG_W - NUM_LINES;

    logic [NUM_LINES-1:0] flags;
    logic [NUM_LINES-1:0] lvl, rose, fell;
    logic                 unused_hi;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irqf_sync #(
            .STAGES (SYNC_STAGES),
            .IDLE   (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[i]),
            .level (lvl[i]),
            .rose  (rose[i]),
            .fell  (fell[i])
        );

        irqf_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .sense  (sense_e'(sense_sel[2*i +: 2])),
            .level  (lvl[i]),
            .rose   (rose[i]),
            .fell   (fell[i]),
            .rd_en  (rd_en),
            .wr_en  (wr_en),
            .wr_bit (wr_data[i]),
            .ack    (ack[i]),
            .flag   (flags[i])
        );
    end

    assign unused_hi = ^wr_data[REG_W-1:NUM_LINES];
    assign rd_data   = {{PAD_W{1'b0}}, flags};
    assign req       = flags;
    assign any_req   = |flags;

endmodule

// File: tb/sim_ext_irq_flags.sv
`timescale 1ns/1ps
module sim_ext_irq_flags;
    localparam real CLK_PERIOD = 8.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_en, wr_en;
    logic [15:0] wr_data, rd_data;
    logic [7:0]  pin_in, ack, req;
    logic [15:0] sense_sel;
    logic        any_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .sense_sel(sense_sel), .ack(ack), .req(req), .any_req(any_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_word(input string tag, input logic [15:0] exp);
        checks++;
        if (rd_data !== exp || req !== exp[7:0] || any_req !== (|exp[7:0])) begin
            failures++;
            $display("FAIL %s: rd_data=%h req=%h any_req=%b expected rd_data=%h req=%h any_req=%b",
                     tag, rd_data, req, any_req, exp, exp[7:0], |exp[7:0]);
        end
    endtask

    task automatic do_read();
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d; tick(1); wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp;
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
        pin_in = 8'hFF; ack = '0; sense_sel = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check_word("R1 reset state", 16'h0000);

        do_write(16'hFF00);
        check_word("R2 reserved bits written", 16'h0000);

        // R4 latency: all pins low, flags appear on the third edge
        pin_in = 8'h00;
        tick(2);
        check_word("R4 before third edge", 16'h0000);
        tick(1);
        check_word("R4 on third edge", 16'h00FF);

        // R4/R3 exhaustive level sweep
        for (int p = 0; p < 256; p++) begin
            pin_in = p[7:0];
            tick(3);
            check_word("R4 level pattern", {8'h00, ~p[7:0]});
        end

        // R9 level mode ignores ack and armed write
        pin_in = 8'hF7;
        tick(3);
        check_word("R4 line3 low", 16'h0008);
        do_read();
        do_write(16'h0000);
        ack = 8'hFF; tick(1); ack = '0;
        check_word("R9 level ignores write and ack", 16'h0008);
        pin_in = 8'hFF;
        tick(3);
        check_word("R4 line3 released", 16'h0000);

        // R3/R5/R6/R9 sweep over every sense code and line
        for (int m = 0; m < 4; m++) begin
            for (int ln = 0; ln < 8; ln++) begin
                logic [15:0] bitw;
                bitw = 16'(1) << ln;
                sense_sel = {8{m[1:0]}};
                pin_in = ~bitw[7:0];
                tick(3);
                exp = (m == 2) ? 16'h0000 : bitw;
                check_word("R5 falling edge per mode", exp);
                pin_in = 8'hFF;
                tick(3);
                exp = (m == 0) ? 16'h0000 : bitw;
                check_word("R6 R5 rising edge per mode", exp);
                tick(5);
                check_word("R6 flag holds", exp);
                ack = bitw[7:0]; tick(1); ack = '0;
                check_word("R9 ack clears", 16'h0000);
            end
        end

        // R7/R8 on line 5, falling mode
        sense_sel = {8{2'b01}};
        pin_in = 8'hDF; tick(3); pin_in = 8'hFF; tick(3);
        check_word("R5 line5 set", 16'h0020);
        do_write(16'h0000);
        check_word("R7 write0 without read", 16'h0020);
        do_write(16'hFFFF);
        check_word("R7 write1 never sets", 16'h0020);
        do_read();
        check_word("R8 read does not clear", 16'h0020);
        do_write(16'h0000);
        check_word("R8 read then write0 clears", 16'h0000);

        pin_in = 8'hDF; tick(3); pin_in = 8'hFF; tick(3);
        do_read();
        do_write(16'h00FF);
        check_word("R8 write1 keeps flag", 16'h0020);
        do_write(16'h0000);
        check_word("R8 marker spent by write", 16'h0020);
        do_read();
        do_write(16'h0000);
        check_word("R8 rearmed clear", 16'h0000);

        do_read();
        pin_in = 8'hDF; tick(3); pin_in = 8'hFF; tick(3);
        do_write(16'h0000);
        check_word("R8 read of zero arms nothing", 16'h0020);
        do_read();
        do_write(16'h0000);
        check_word("R8 final clear", 16'h0000);

        // R10 on line 2, both-edge mode
        sense_sel = {8{2'b11}};
        pin_in = 8'hFB; tick(3);
        check_word("R5 line2 set", 16'h0004);
        do_read();
        pin_in = 8'hFF;
        tick(2);
        wr_en = 1'b1; wr_data = 16'h0000; tick(1); wr_en = 1'b0;
        check_word("R10 edge beats write clear", 16'h0004);
        tick(1);
        check_word("R10 flag still held", 16'h0004);
        pin_in = 8'hFB;
        tick(2);
        ack = 8'h04; tick(1); ack = '0;
        check_word("R10 edge beats ack", 16'h0004);
        ack = 8'h04; tick(1); ack = '0;
        check_word("R9 ack clears after collision", 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule